// File: doc/BRIEF.md
# Multi-channel ADC sample sequencer

This block is the digital sample engine that sits in front of a successive-approximation converter. Software writes four configuration words that set an ordered list of up to eight sequence slots, each naming a physical input channel. The same words set, for every physical channel, how many conversions to take and how to combine them, and they set the pause inserted between conversions. Once started, the engine walks the slot list and asks the converter for one conversion at a time over a request/done handshake. It folds the conversions of a slot into one value by mean or by median, tags that value with its channel number and pushes it into a 32-entry result FIFO.

The host drains the FIFO through a pop strobe and a combinational head-of-queue word, and it polls a busy field and the FIFO fill level, full flag and empty flag. A level interrupt rises once the fill level reaches a programmed threshold. A run is one pass over the list. In continuous mode the engine restarts the list until a stop request lets the slot in progress complete and then halts.

Top module: `adc_seq_engine`

## Requirements
- R1: After reset the busy field is 0, the fill level is 0, the empty flag is 1, the full, overflow and interrupt outputs are 0, and no conversion is requested.
- R2: Control word (address 0) fields: bit 0 engine enable, bit 1 continuous, bit 2 start, bit 3 stop, bit 4 interrupt enable, bits 9:5 threshold. A write with bit 2 set while idle starts a pass only if bit 0 of that same write is 1, and busy bit 0 is high in the cycle after the write's edge. A start with bit 0 clear leaves the engine idle and issues no request.
- R3: Slot word (address 1): slot i holds a channel number in bits 3i+2:3i, and bits 26:24 hold the last slot index, where 0 means one slot. Slots are converted in ascending index order and `convChan` carries the slot's channel.
- R4: Averaging word (address 2): channel c has a count field in bits 2c+1:2c, with values 0 to 3 selecting 1, 2, 4 or 8 conversions. It has a mode field in bits 2c+17:2c+16, where 0 is none, 1 is mean, 2 is median and 3 behaves as none. Modes none and 3 take exactly one conversion and pass it through unchanged, whatever the count field holds.
- R5: Mean mode outputs the sum of the N conversions shifted right by log2(N).
- R6: Median mode outputs the value at sorted position (N-1)/2, rounded down. For even N this is the lower of the two middle values, and equal values count separately.
- R7: A FIFO entry holds the channel in bits 14:12 and the value in bits 11:0. Entries leave in push order. `fifoRdData` shows the head while the FIFO is not empty, and `fifoRdEn` removes it at the clock edge.
- R8: The FIFO holds 32 entries and raises the full flag at 32. A result pushed while the FIFO is full is dropped and sets a sticky overflow flag that only reset clears.
- R9: While the FIFO is empty, `fifoRdData` is zero and a pop leaves the fill level at zero.
- R10: The interrupt output is high exactly when interrupt enable is set and the fill level is at least the threshold.
- R11: Without the continuous bit, a pass ends after the last slot and busy returns to 0. With it, the list restarts from slot 0. A stop lets the current slot finish and push its result, after which busy drops to 0 and no further conversions are requested.
- R12: Delay word (address 3): bits 7:0 hold a count and bits 9:8 a time-base select, where one tick is 4^select clocks. Within a run, the next request comes (count+1)*4^select+1 cycles after the cycle in which done was high.
- R13: Busy bit 0 is high while conversions are requested, awaited or spaced apart. Bit 1 is high for the single cycle in which a slot's result is formed and pushed. Bit 2 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Configuration write strobe |
| regAddr | input | 2 | Configuration word select |
| regWrData | input | 32 | Configuration write data |
| convReq | output | 1 | One-cycle conversion request |
| convChan | output | 3 | Channel to convert |
| convDone | input | 1 | Conversion finished, result valid |
| convResult | input | 12 | Conversion result |
| fifoRdEn | input | 1 | Pop the FIFO head |
| fifoRdData | output | 15 | FIFO head: channel and value |
| fifoCount | output | 6 | FIFO fill level |
| fifoFull | output | 1 | FIFO holds 32 entries |
| fifoEmpty | output | 1 | FIFO holds no entry |
| fifoOverflow | output | 1 | Sticky: a result was dropped |
| busy | output | 3 | {reserved 0, averaging, sampling} |
| fifoIrq | output | 1 | Fill-level interrupt |

## Verification
The hardest state to reach is a full FIFO that still receives results. Only completed slots push, so the bench programs an eight-slot list in pass-through mode and runs five back-to-back passes without draining, which forces eight results past capacity. It then pops all 32 entries to show that the oldest results survived in order. The stop request is also awkward to time, because it arrives at an arbitrary point of a continuous run. The bench therefore compares the FIFO level with the number of conversions the converter model actually served, and it watches for any request after busy has fallen.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int ChanW = 3;   // physical channel number width
  localparam int IdxW  = 3;   // conversion index width, up to 8 per slot

  typedef enum logic [1:0] {
    AVG_NONE   = 2'd0,
    AVG_MEAN   = 2'd1,
    AVG_MEDIAN = 2'd2,
    AVG_RSVD   = 2'd3
  } avgMode_e;

  // strobes from the sequencer control to the datapath
  typedef struct packed {
    logic             capture;    // store convResult at sampleIdx
    logic             push;       // form result and push to FIFO
    logic [IdxW-1:0]  sampleIdx;
    avgMode_e         mode;       // effective mode (reserved mapped to none)
    logic [1:0]       log2n;      // log2 of conversions in this slot
    logic [ChanW-1:0] chan;
  } seqStrobe_t;
endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NumSlots = 8,
  parameter int NumChans = 8,
  parameter int DlyW     = 8,
  parameter int TbStep   = 2,
  parameter int ThrW     = 5,
  parameter int RegW     = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [RegW-1:0]  regWrData,
  output logic             convReq,
  output logic [ChanW-1:0] convChan,
  input  logic             convDone,
  output seqStrobe_t       strobe,
  output logic             sampleBusy,
  output logic             avgBusy,
  output logic             irqEn,
  output logic [ThrW-1:0]  irqThr
);
  localparam int SlotW      = $clog2(NumSlots);
  localparam int PreW       = 3 * TbStep + 1;
  localparam int ListMaxLsb = 24;
  localparam int ModeLsb    = 16;
  localparam int ThrLsb     = 5;
  localparam logic [1:0] AddrCtrl = 2'd0;
  localparam logic [1:0] AddrList = 2'd1;
  localparam logic [1:0] AddrAvg  = 2'd2;
  localparam logic [1:0] AddrDly  = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_WAIT, S_GAP, S_RESULT} state_e;

  state_e                   state;
  logic                     enableR, contR, irqEnR, stopPend;
  logic [ThrW-1:0]          thrR;
  logic [NumSlots*ChanW-1:0] slotR;
  logic [SlotW-1:0]         maxIdxR, slotIdx;
  logic [2*NumChans-1:0]    cntR, modeR;
  logic [DlyW-1:0]          dlyCntR, gapCnt;
  logic [1:0]               tbSelR;
  logic [PreW-1:0]          pre, preLimit;
  logic [IdxW-1:0]          convIdx, lastIdx;

  logic                     wrCtl, startHit, stopHit, stopNow;
  logic [ChanW-1:0]         curChan;
  avgMode_e                 curMode;
  logic [1:0]               curCnt, effLog2n;
  logic                     singleConv;

  // ---------------- configuration words ----------------
  assign wrCtl    = regWrEn && (regAddr == AddrCtrl);
  assign startHit = wrCtl && regWrData[2] && regWrData[0];
  assign stopHit  = wrCtl && regWrData[3];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableR <= 1'b0;
      contR   <= 1'b0;
      irqEnR  <= 1'b0;
      thrR    <= '0;
      slotR   <= '0;
      maxIdxR <= '0;
      cntR    <= '0;
      modeR   <= '0;
      dlyCntR <= '0;
      tbSelR  <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        AddrCtrl: begin
          enableR <= regWrData[0];
          contR   <= regWrData[1];
          irqEnR  <= regWrData[4];
          thrR    <= regWrData[ThrLsb +: ThrW];
        end
        AddrList: begin
          slotR   <= regWrData[NumSlots*ChanW-1:0];
          maxIdxR <= regWrData[ListMaxLsb +: SlotW];
        end
        AddrAvg: begin
          cntR    <= regWrData[2*NumChans-1:0];
          modeR   <= regWrData[ModeLsb +: 2*NumChans];
        end
        AddrDly: begin
          dlyCntR <= regWrData[DlyW-1:0];
          tbSelR  <= regWrData[DlyW +: 2];
        end
        default: ;
      endcase
    end
  end

  // ---------------- current slot decode ----------------
  assign curChan    = slotR[slotIdx*ChanW +: ChanW];
  assign curMode    = avgMode_e'(modeR[curChan*2 +: 2]);
  assign curCnt     = cntR[curChan*2 +: 2];
  assign singleConv = (curMode == AVG_NONE) || (curMode == AVG_RSVD);
  assign effLog2n   = singleConv ? 2'd0 : curCnt;
  assign lastIdx    = IdxW'((4'd1 << effLog2n) - 4'd1);
  assign preLimit   = (PreW'(1) << (TbStep * int'(tbSelR))) - PreW'(1);
  assign stopNow    = stopPend || stopHit;

  // ---------------- sequencing state machine ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      slotIdx  <= '0;
      convIdx  <= '0;
      gapCnt   <= '0;
      pre      <= '0;
      stopPend <= 1'b0;
    end else begin
      if (stopHit && state != S_IDLE) stopPend <= 1'b1;
      case (state)
        S_IDLE: begin
          stopPend <= 1'b0;
          if (startHit) begin
            state   <= S_REQ;
            slotIdx <= '0;
            convIdx <= '0;
          end
        end
        S_REQ: state <= S_WAIT;
        S_WAIT: begin
          if (convDone) begin
            if (convIdx == lastIdx) begin
              state <= S_RESULT;
            end else begin
              convIdx <= convIdx + 1'b1;
              gapCnt  <= dlyCntR;
              pre     <= '0;
              state   <= S_GAP;
            end
          end
        end
        S_GAP: begin
          if (pre == preLimit) begin
            pre <= '0;
            if (gapCnt == '0) state <= S_REQ;
            else              gapCnt <= gapCnt - 1'b1;
          end else begin
            pre <= pre + 1'b1;
          end
        end
        S_RESULT: begin
          convIdx <= '0;
          gapCnt  <= dlyCntR;
          pre     <= '0;
          if (slotIdx == maxIdxR) begin
            if (contR && !stopNow) begin
              slotIdx <= '0;
              state   <= S_GAP;
            end else begin
              state <= S_IDLE;
            end
          end else if (stopNow) begin
            state <= S_IDLE;
          end else begin
            slotIdx <= slotIdx + 1'b1;
            state   <= S_GAP;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // ---------------- outputs ----------------
  assign convReq    = (state == S_REQ);
  assign convChan   = curChan;
  assign sampleBusy = (state == S_REQ) || (state == S_WAIT) || (state == S_GAP);
  assign avgBusy    = (state == S_RESULT);
  assign irqEn      = irqEnR;
  assign irqThr     = thrR;

  always_comb begin
    strobe.capture   = (state == S_WAIT) && convDone;
    strobe.push      = (state == S_RESULT);
    strobe.sampleIdx = convIdx;
    strobe.mode      = singleConv ? AVG_NONE : curMode;
    strobe.log2n     = effLog2n;
    strobe.chan      = curChan;
  end

  // R2: busy is visible on the first edge after an accepted start
  a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && startHit && enableR == enableR) |=> sampleBusy);

  // R12: each conversion request lasts one cycle
  a_r12_req_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    convReq |=> !convReq);

  // R11: a stop seen while a result is formed ends the run
  a_r11_stop_winds_down: assert property (@(posedge clk) disable iff (!rstN)
    (avgBusy && stopNow) |=> (!sampleBusy && !avgBusy && !convReq));

  // R13: a result cycle only follows a finished conversion
  a_r13_result_after_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(avgBusy) |-> $past(convDone));
endmodule

// File: rtl/adc_seq_dpath.sv
module adc_seq_dpath
  import adc_seq_pkg::*;
#(
  parameter int SampleW = 12,
  parameter int Depth   = 32,
  parameter int ThrW    = 5
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  seqStrobe_t                 strobe,
  input  logic [SampleW-1:0]         convResult,
  input  logic                       rdEn,
  input  logic                       irqEn,
  input  logic [ThrW-1:0]            irqThr,
  output logic [ChanW+SampleW-1:0]   rdData,
  output logic [$clog2(Depth+1)-1:0] count,
  output logic                       full,
  output logic                       empty,
  output logic                       overflow,
  output logic                       irq
);
  localparam int MaxN   = 1 << IdxW;
  localparam int CntNW  = IdxW + 1;
  localparam int SumW   = SampleW + IdxW;
  localparam int PtrW   = $clog2(Depth);
  localparam int CntW   = $clog2(Depth + 1);
  localparam int EntryW = ChanW + SampleW;

  logic [SampleW-1:0]    smp [MaxN];
  logic [CntNW-1:0]      nValid, kSel;
  logic [SumW-1:0]       sum;
  logic [SampleW-1:0]    meanVal, medVal, resultVal;
  logic [MaxN*CntNW-1:0] lessFlat, leqFlat;

  // ---------------- conversion capture ----------------
  always_ff @(posedge clk) begin
    if (strobe.capture) smp[strobe.sampleIdx] <= convResult;
  end

  assign nValid = CntNW'(1) << strobe.log2n;
  assign kSel   = (nValid - CntNW'(1)) >> 1;

  // ---------------- mean ----------------
  always_comb begin
    sum = '0;
    for (int i = 0; i < MaxN; i++) begin
      if (CntNW'(i) < nValid) sum = sum + SumW'(smp[i]);
    end
    meanVal = SampleW'(sum >> strobe.log2n);
  end

  // ---------------- median: rank of each element ----------------
  for (genvar gi = 0; gi < MaxN; gi++) begin : g_rank
    logic [CntNW-1:0] less, leq;
    always_comb begin
      less = '0;
      leq  = '0;
      for (int j = 0; j < MaxN; j++) begin
        if (CntNW'(j) < nValid) begin
          if (smp[j] <  smp[gi]) less = less + 1'b1;
          if (smp[j] <= smp[gi]) leq  = leq + 1'b1;
        end
      end
    end
    assign lessFlat[gi*CntNW +: CntNW] = less;
    assign leqFlat[gi*CntNW +: CntNW]  = leq;
  end

  always_comb begin
    medVal = smp[0];
    for (int i = MaxN - 1; i >= 0; i--) begin
      if ((CntNW'(i) < nValid) &&
          (lessFlat[i*CntNW +: CntNW] <= kSel) &&
          (leqFlat[i*CntNW +: CntNW] > kSel))
        medVal = smp[i];
    end
  end

  always_comb begin
    case (strobe.mode)
      AVG_MEAN:   resultVal = meanVal;
      AVG_MEDIAN: resultVal = medVal;
      default:    resultVal = smp[0];
    endcase
  end

  // ---------------- result FIFO ----------------
  logic [EntryW-1:0] mem [Depth];
  logic [PtrW-1:0]   wrPtr, rdPtr;
  logic              pushOk, popOk;

  assign full   = (count == CntW'(Depth));
  assign empty  = (count == '0);
  assign pushOk = strobe.push && !full;
  assign popOk  = rdEn && !empty;

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= {strobe.chan, resultVal};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (pushOk) wrPtr <= wrPtr + 1'b1;
      if (popOk)  rdPtr <= rdPtr + 1'b1;
      if (pushOk && !popOk)      count <= count + 1'b1;
      else if (popOk && !pushOk) count <= count - 1'b1;
      if (strobe.push && full) overflow <= 1'b1;
    end
  end

  assign rdData = empty ? '0 : mem[rdPtr];
  assign irq    = irqEn && (count >= CntW'(irqThr));

  // R8: a push into a full FIFO is dropped and flagged
  a_r8_full_drop: assert property (@(posedge clk) disable iff (!rstN)
    (full && strobe.push && !rdEn) |=> (full && overflow));

  // R8: overflow never clears once set
  a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  // R9: popping an empty FIFO leaves it empty
  a_r9_empty_read: assert property (@(posedge clk) disable iff (!rstN)
    (empty && rdEn && !strobe.push) |=> empty);

  // R7: an accepted push without a pop grows the level by one
  a_r7_push_grows: assert property (@(posedge clk) disable iff (!rstN)
    (!full && strobe.push && !rdEn) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/adc_seq_engine.sv
module adc_seq_engine
  import adc_seq_pkg::*;
#(
  parameter int SampleW   = 12,
  parameter int FifoDepth = 32,
  parameter int ThrW      = 5
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           regWrEn,
  input  logic [1:0]                     regAddr,
  input  logic [31:0]                    regWrData,
  output logic                           convReq,
  output logic [ChanW-1:0]               convChan,
  input  logic                           convDone,
  input  logic [SampleW-1:0]             convResult,
  input  logic                           fifoRdEn,
  output logic [ChanW+SampleW-1:0]       fifoRdData,
  output logic [$clog2(FifoDepth+1)-1:0] fifoCount,
  output logic                           fifoFull,
  output logic                           fifoEmpty,
  output logic                           fifoOverflow,
  output logic [2:0]                     busy,
  output logic                           fifoIrq
);
  seqStrobe_t      strobe;
  logic            sampleBusy, avgBusy, irqEn;
  logic [ThrW-1:0] irqThr;

  adc_seq_ctrl #(
    .ThrW(ThrW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .convReq(convReq), .convChan(convChan), .convDone(convDone),
    .strobe(strobe), .sampleBusy(sampleBusy), .avgBusy(avgBusy),
    .irqEn(irqEn), .irqThr(irqThr)
  );

  adc_seq_dpath #(
    .SampleW(SampleW), .Depth(FifoDepth), .ThrW(ThrW)
  ) u_dpath (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .convResult(convResult),
    .rdEn(fifoRdEn), .irqEn(irqEn), .irqThr(irqThr),
    .rdData(fifoRdData), .count(fifoCount),
    .full(fifoFull), .empty(fifoEmpty), .overflow(fifoOverflow),
    .irq(fifoIrq)
  );

  assign busy = {1'b0, avgBusy, sampleBusy};
endmodule

// File: tb/sim_adc_seq_engine.sv
module sim_adc_seq_engine;
  localparam int Lat = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic        convReq;
  logic [2:0]  convChan;
  logic        convDone = 1'b0;
  logic [11:0] convResult = '0;
  logic        fifoRdEn = 1'b0;
  logic [14:0] fifoRdData;
  logic [5:0]  fifoCount;
  logic        fifoFull, fifoEmpty, fifoOverflow, fifoIrq;
  logic [2:0]  busy;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int cyc = 0;

  // converter model state
  int valTab  [256];
  int chanLog [256];
  int reqCyc  [256];
  int doneCyc [256];
  int busySnap[256];
  int reqIdx = 0, doneIdx = 0, snapIdx = 0, pend = 0;
  bit snapPend = 0;
  int resHold = 0;

  adc_seq_engine u0 (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .convReq(convReq), .convChan(convChan), .convDone(convDone), .convResult(convResult),
    .fifoRdEn(fifoRdEn), .fifoRdData(fifoRdData), .fifoCount(fifoCount),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .fifoOverflow(fifoOverflow),
    .busy(busy), .fifoIrq(fifoIrq)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    convDone <= 1'b0;
    if (snapPend) begin
      busySnap[snapIdx] = int'(busy);
      snapIdx++;
      snapPend = 0;
    end
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        convDone   <= 1'b1;
        convResult <= 12'(resHold);
        doneCyc[doneIdx] = cyc;
        doneIdx++;
        snapPend = 1;
      end
    end
    if (convReq) begin
      reqCyc[reqIdx]  = cyc;
      chanLog[reqIdx] = int'(convChan);
      resHold = valTab[reqIdx];
      reqIdx++;
      pend = Lat;
    end
  end

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ctlWord(bit en, bit cont, bit start, bit stop, bit ie, int thr);
    return 32'(en) | (32'(cont) << 1) | (32'(start) << 2) | (32'(stop) << 3) |
           (32'(ie) << 4) | (32'(thr) << 5);
  endfunction

  function automatic logic [31:0] avgWord(int ch, int mode, int cnt);
    return (32'(cnt) << (2*ch)) | (32'(mode) << (16 + 2*ch));
  endfunction

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // start a pass and check that busy is already visible
  task automatic startRun(input bit cont, input bit ie, input int thr);
    regWrite(2'd0, ctlWord(1, cont, 1, 0, ie, thr));
    checkEq("R2", "busy sample bit after start", int'(busy[0]), 1);
  endtask

  task automatic waitIdle();
    for (int n = 0; n < 5000; n++) begin
      @(negedge clk);
      if (busy == 3'b000) break;
    end
  endtask

  task automatic popEntry(output int d);
    @(negedge clk);
    d = int'(fifoRdData);
    fifoRdEn = 1'b1;
    @(negedge clk);
    fifoRdEn = 1'b0;
  endtask

  task automatic singleSlot(input int ch);
    regWrite(2'd1, 32'(ch));
  endtask

  task automatic t_reset();
    checkEq("R1", "busy", int'(busy), 0);
    checkEq("R1", "count", int'(fifoCount), 0);
    checkEq("R1", "empty", int'(fifoEmpty), 1);
    checkEq("R1", "full", int'(fifoFull), 0);
    checkEq("R1", "overflow", int'(fifoOverflow), 0);
    checkEq("R1", "irq", int'(fifoIrq), 0);
    checkEq("R1", "convReq", int'(convReq), 0);
  endtask

  task automatic t_passThrough();
    int base = reqIdx;
    int d;
    singleSlot(5);
    regWrite(2'd2, avgWord(5, 0, 3));
    valTab[base] = 'hABC;
    startRun(0, 0, 0);
    waitIdle();
    checkEq("R4", "mode none conversions", reqIdx - base, 1);
    checkEq("R3", "channel requested", chanLog[base], 5);
    checkEq("R13", "busy in result cycle", busySnap[snapIdx-1], 2);
    checkEq("R7", "count after pass", int'(fifoCount), 1);
    popEntry(d);
    checkEq("R7", "entry chan/value", d, (5 << 12) | 'hABC);
    checkEq("R7", "empty after pop", int'(fifoEmpty), 1);
  endtask

  task automatic t_mean();
    int base = reqIdx;
    int d;
    singleSlot(3);
    regWrite(2'd2, avgWord(3, 1, 2));
    valTab[base] = 100; valTab[base+1] = 200; valTab[base+2] = 300; valTab[base+3] = 401;
    startRun(0, 0, 0);
    waitIdle();
    checkEq("R4", "mean of 4 conversions", reqIdx - base, 4);
    popEntry(d);
    checkEq("R5", "mean value", d, (3 << 12) | 250);
  endtask

  task automatic medianRun(input int cnt, input int v0, input int v1, input int v2,
                           input int v3, input int v4, input int v5, input int v6,
                           input int v7, input int expVal);
    int base = reqIdx;
    int d;
    singleSlot(2);
    regWrite(2'd2, avgWord(2, 2, cnt));
    valTab[base] = v0; valTab[base+1] = v1; valTab[base+2] = v2; valTab[base+3] = v3;
    valTab[base+4] = v4; valTab[base+5] = v5; valTab[base+6] = v6; valTab[base+7] = v7;
    startRun(0, 0, 0);
    waitIdle();
    checkEq("R4", "median conversions", reqIdx - base, 1 << cnt);
    popEntry(d);
    checkEq("R6", "median value", d, (2 << 12) | expVal);
  endtask

  task automatic t_median();
    medianRun(3, 9, 1, 8, 2, 7, 3, 6, 4, 4);
    medianRun(1, 50, 20, 0, 0, 0, 0, 0, 0, 20);
    medianRun(2, 10, 40, 30, 20, 0, 0, 0, 0, 20);
    medianRun(2, 7, 7, 3, 9, 0, 0, 0, 0, 7);
  endtask

  task automatic t_reservedMode();
    int base = reqIdx;
    int d;
    singleSlot(1);
    regWrite(2'd2, avgWord(1, 3, 2));
    valTab[base] = 77;
    startRun(0, 0, 0);
    waitIdle();
    checkEq("R4", "reserved mode conversions", reqIdx - base, 1);
    popEntry(d);
    checkEq("R4", "reserved mode value", d, (1 << 12) | 77);
  endtask

  task automatic t_list();
    int base = reqIdx;
    int d;
    regWrite(2'd1, 32'(6) | (32'(1) << 3) | (32'(4) << 6) | (32'(2) << 24));
    regWrite(2'd2, 32'h0);
    valTab[base] = 11; valTab[base+1] = 22; valTab[base+2] = 33;
    startRun(0, 0, 0);
    waitIdle();
    checkEq("R3", "slots converted", reqIdx - base, 3);
    checkEq("R3", "slot0 chan", chanLog[base], 6);
    checkEq("R3", "slot1 chan", chanLog[base+1], 1);
    checkEq("R3", "slot2 chan", chanLog[base+2], 4);
    popEntry(d); checkEq("R7", "first entry", d, (6 << 12) | 11);
    popEntry(d); checkEq("R7", "second entry", d, (1 << 12) | 22);
    popEntry(d); checkEq("R7", "third entry", d, (4 << 12) | 33);
  endtask

  task automatic t_gate();
    int base = reqIdx;
    singleSlot(0);
    regWrite(2'd0, ctlWord(0, 0, 1, 0, 0, 0));
    checkEq("R2", "busy after gated start", int'(busy), 0);
    repeat (20) @(negedge clk);
    checkEq("R2", "requests after gated start", reqIdx - base, 0);
    checkEq("R2", "fifo after gated start", int'(fifoCount), 0);
  endtask

  task automatic delayRun(input int cnt, input int sel);
    int base = reqIdx;
    int dbase = doneIdx;
    int d;
    singleSlot(0);
    regWrite(2'd2, avgWord(0, 1, 1));
    regWrite(2'd3, 32'(cnt) | (32'(sel) << 8));
    valTab[base] = 10; valTab[base+1] = 20;
    startRun(0, 0, 0);
    waitIdle();
    checkEq("R12", "gap done->req", reqCyc[base+1] - doneCyc[dbase],
            (cnt + 1) * (1 << (2*sel)) + 1);
    popEntry(d);
    checkEq("R5", "two-sample mean", d, 15);
  endtask

  task automatic t_delay();
    delayRun(3, 1);
    delayRun(0, 0);
    delayRun(2, 2);
    regWrite(2'd3, 32'h0);
  endtask

  task automatic t_irq();
    int base = reqIdx;
    int d;
    singleSlot(0);
    regWrite(2'd2, 32'h0);
    for (int k = 0; k < 3; k++) valTab[base+k] = k;
    startRun(0, 1, 3); waitIdle();
    startRun(0, 1, 3); waitIdle();
    checkEq("R10", "irq below threshold", int'(fifoIrq), 0);
    startRun(0, 1, 3); waitIdle();
    checkEq("R10", "irq at threshold", int'(fifoIrq), 1);
    for (int k = 0; k < 3; k++) popEntry(d);
    checkEq("R10", "irq after drain", int'(fifoIrq), 0);
    regWrite(2'd0, ctlWord(1, 0, 0, 0, 0, 0));
  endtask

  task automatic t_continuous();
    int base = reqIdx;
    int n;
    int d;
    singleSlot(7);
    regWrite(2'd2, 32'h0);
    regWrite(2'd3, 32'd5);
    for (int k = 0; k < 40; k++) valTab[base+k] = 500 + k;
    startRun(1, 0, 0);
    repeat (60) @(negedge clk);
    checkEq("R11", "still busy in continuous", int'(busy != 3'b000), 1);
    regWrite(2'd0, ctlWord(1, 1, 0, 1, 0, 0));
    waitIdle();
    n = reqIdx - base;
    checkEq("R11", "continuous restarted", int'(n >= 2), 1);
    repeat (40) @(negedge clk);
    checkEq("R11", "no request after stop", reqIdx - base, n);
    checkEq("R11", "every slot pushed", int'(fifoCount), n);
    checkEq("R11", "busy after stop", int'(busy), 0);
    for (int k = 0; k < n; k++) begin
      popEntry(d);
      checkEq("R7", "continuous entry", d, (7 << 12) | (500 + k));
    end
    regWrite(2'd3, 32'h0);
    regWrite(2'd0, ctlWord(1, 0, 0, 0, 0, 0));
  endtask

  task automatic t_overflow();
    int base = reqIdx;
    int d;
    logic [31:0] lw = 32'(7) << 24;
    regWrite(2'd1, lw);
    regWrite(2'd2, 32'h0);
    for (int k = 0; k < 40; k++) valTab[base+k] = k + 1;
    for (int r = 0; r < 5; r++) begin
      startRun(0, 0, 0);
      waitIdle();
    end
    checkEq("R8", "count at capacity", int'(fifoCount), 32);
    checkEq("R8", "full flag", int'(fifoFull), 1);
    checkEq("R8", "overflow flag", int'(fifoOverflow), 1);
    for (int k = 0; k < 32; k++) begin
      popEntry(d);
      checkEq("R8", "kept entry", d, k + 1);
    end
    checkEq("R9", "empty after drain", int'(fifoEmpty), 1);
    checkEq("R9", "empty read data", int'(fifoRdData), 0);
    popEntry(d);
    checkEq("R9", "popped empty data", d, 0);
    checkEq("R9", "count after empty pop", int'(fifoCount), 0);
    checkEq("R8", "overflow stays set", int'(fifoOverflow), 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_passThrough();
    t_mean();
    t_median();
    t_reservedMode();
    t_list();
    t_gate();
    t_delay();
    t_irq();
    t_continuous();
    t_overflow();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule